// File: doc/BRIEF.md
# Remote Terminal Status Flag Controller

This block holds the flag bits that a remote terminal reports in its status word and the three fault bits of its built-in-test word. It takes fault reports from the rest of the terminal, request lines from the subsystem, and a command class from an upstream decoder. From these it computes the status bits that the serial transmitter sends with the current response. The transmitter and the command decoder are not part of this block.

Flag clearing is programmable. With the option master enable inactive, the terminal flag and subsystem flag latch until a reset-terminal command or a hardware reset. With it active, three independent options select when a flag is shown and when it is dropped. Status-update shows it to an immediate status poll. Next-status shows it in the very next ordinary status. BIT-decode keeps the fault evidence through a built-in-test word read that follows the fault.

A command is presented as a single-cycle `cmd_valid` pulse with a 3-bit class on `cmd_kind`. The class codes are 0 other valid command, 1 transmit-status poll, 2 transmit-last-command poll, 3 transmit BIT word, 4 reset terminal, 5 inhibit terminal flag, 6 override inhibit, and 7 dynamic bus control. Classes 1 and 2 are "polls". Every other class is "non-poll". All inputs are active high unless the name ends in `_n`. Each output is registered one cycle after the event that changes it. The one exception is `sts_ssf` in option mode, which also follows the live `ssf_err_n` level directly.

Top module: `rt_status_ctl`

## Requirements
- R1: With `opt_en_n` high, `sts_ssf` sets the cycle after `ssf_err_n` is low or `hs_fail` pulses, and stays set until a class 4 command or reset.
- R2: With `opt_en_n` high, `sts_tf` sets the cycle after any of `lt_fail`, `tx_timeout`, `selftest_fail` or `addr_par_err`, and stays set until a class 4 command or reset; after reset every output is 0.
- R3: A class 5 command forces `sts_tf` to 0 from the next cycle. A class 6 or class 4 command, or reset, lifts that suppression.
- R4: After a non-poll command, `sts_busy`/`sts_srq` clear. On the SAMPLE_TICKS-th (default 2) `tick_en` pulse after the command, they take the inverted `busy_n`/`srq_n` levels.
- R5: A rising edge of `merr_req` in one of the MERR_WIN (default 25) cycles after a non-poll command sets `sts_merr`. An edge outside that window does not. The bit clears on the next non-poll command.
- R6: A class 7 command with `dbc_acc_n` low sets `sts_dbca` and gives a one-cycle `dbc_req` pulse. With `dbc_acc_n` high, neither happens. Any other non-poll command clears `sts_dbca`.
- R7: With only `opt_en_n` low, every non-poll command clears both flags and the BIT bits. A pulsed fault is then not shown, but `sts_ssf` follows a `ssf_err_n` held low.
- R8: With `opt_upd_n` low, a poll made before any non-poll command since the fault shows the flag. Repeated polls keep showing it, and the next non-poll command clears it.
- R9: With `opt_next_n` low, a flag appears after the first non-poll command following the fault. Polls do not change it, and the following non-poll command clears it.
- R10: `bit_txto`, `bit_hsf` and `bit_ltf` set on `tx_timeout`, `hs_fail` and `lt_fail`. With `opt_bitd_n` low, a class 3 command that comes before any other non-poll command since the fault leaves flags and BIT bits unchanged.
- R11: With `opt_en_n` high, the levels of `opt_next_n`, `opt_upd_n` and `opt_bitd_n` have no effect on any output.
- R12: Poll commands leave `sts_busy`, `sts_srq`, `sts_merr` and `sts_dbca` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow sampling tick, one cycle wide |
| cmd_valid | input | 1 | Validated command for this terminal |
| cmd_kind | input | 3 | Command class code |
| busy_n | input | 1 | Subsystem busy, active low |
| srq_n | input | 1 | Subsystem service request, active low |
| merr_req | input | 1 | Request to force message error |
| dbc_acc_n | input | 1 | Dynamic bus control accept, active low |
| ssf_err_n | input | 1 | Subsystem error level, active low |
| hs_fail | input | 1 | Data handshake failure pulse |
| tx_timeout | input | 1 | Transmitter timeout pulse |
| lt_fail | input | 1 | Loopback compare failure pulse |
| selftest_fail | input | 1 | Self-test failure pulse |
| addr_par_err | input | 1 | Hardwired address parity error |
| opt_en_n | input | 1 | Option master enable, active low |
| opt_next_n | input | 1 | Next-status option, active low |
| opt_upd_n | input | 1 | Status-update option, active low |
| opt_bitd_n | input | 1 | BIT-decode option, active low |
| sts_merr | output | 1 | Message error status bit |
| sts_busy | output | 1 | Busy status bit |
| sts_srq | output | 1 | Service request status bit |
| sts_dbca | output | 1 | Dynamic bus control acceptance bit |
| sts_tf | output | 1 | Terminal flag status bit |
| sts_ssf | output | 1 | Subsystem flag status bit |
| bit_txto | output | 1 | BIT word transmitter timeout bit |
| bit_hsf | output | 1 | BIT word handshake failure bit |
| bit_ltf | output | 1 | BIT word loop test failure bit |
| dbc_req | output | 1 | Dynamic bus control request pulse |

## Verification
The assertions assume that the program option inputs change only while no command or fault is in flight. They also assume that `cmd_valid` is a single-cycle pulse and that a reset-terminal command is judged only in cycles free of fault pulses. The stimulus meets these assumptions. It changes options only between scenarios, after a hardware reset. It spaces every command and fault pulse by idle cycles, and it never lets a fault coincide with a command. A behavioural model in the bench predicts every output on every cycle. It covers faults before, between and after polls, and merr edges just inside and just outside the window.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [2:0] {
    CK_OTHER  = 3'd0,
    CK_POLLST = 3'd1,
    CK_POLLLC = 3'd2,
    CK_BITRD  = 3'd3,
    CK_RESET  = 3'd4,
    CK_INHTF  = 3'd5,
    CK_OVRTF  = 3'd6,
    CK_DBC    = 3'd7
  } cmd_kind_e;

  function automatic logic kind_is_poll(input logic [2:0] k);
    return (k == CK_POLLST) || (k == CK_POLLLC);
  endfunction
endpackage

// File: rtl/sts_sample.sv
module sts_sample #(
  parameter int SAMPLE_TICKS = 2,
  parameter int MERR_WIN     = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic np_cmd,
  input  logic tick_en,
  input  logic busy_n,
  input  logic srq_n,
  input  logic merr_req,
  output logic busy_q,
  output logic srq_q,
  output logic merr_q
);
  localparam int TW = (SAMPLE_TICKS > 1) ? $clog2(SAMPLE_TICKS) : 1;
  localparam int MW = (MERR_WIN > 1) ? $clog2(MERR_WIN) : 1;
  localparam logic [TW-1:0] TLAST = TW'(SAMPLE_TICKS - 1);
  localparam logic [MW-1:0] MLAST = MW'(MERR_WIN - 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic          tarm_q, tarm_d;
  logic          busy_d, srq_d;
  logic [MW-1:0] mcnt_q, mcnt_d;
  logic          mwin_q, mwin_d;
  logic          merr_d, mprev_q;

  always_comb begin
    tcnt_d = tcnt_q;
    tarm_d = tarm_q;
    busy_d = busy_q;
    srq_d  = srq_q;
    if (np_cmd) begin
      tcnt_d = '0;
      tarm_d = 1'b1;
      busy_d = 1'b0;
      srq_d  = 1'b0;
    end else if (tarm_q && tick_en) begin
      tcnt_d = tcnt_q + 1'b1;
      if (tcnt_q == TLAST) begin
        tarm_d = 1'b0;
        busy_d = ~busy_n;
        srq_d  = ~srq_n;
      end
    end
  end

  always_comb begin
    mcnt_d = mcnt_q;
    mwin_d = mwin_q;
    merr_d = merr_q;
    if (np_cmd) begin
      mcnt_d = '0;
      mwin_d = 1'b1;
      merr_d = 1'b0;
    end else if (mwin_q) begin
      if (merr_req && !mprev_q) merr_d = 1'b1;
      mcnt_d = mcnt_q + 1'b1;
      if (mcnt_q == MLAST) mwin_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q  <= '0;
      tarm_q  <= 1'b0;
      busy_q  <= 1'b0;
      srq_q   <= 1'b0;
      mcnt_q  <= '0;
      mwin_q  <= 1'b0;
      merr_q  <= 1'b0;
      mprev_q <= 1'b0;
    end else begin
      tcnt_q  <= tcnt_d;
      tarm_q  <= tarm_d;
      busy_q  <= busy_d;
      srq_q   <= srq_d;
      mcnt_q  <= mcnt_d;
      mwin_q  <= mwin_d;
      merr_q  <= merr_d;
      mprev_q <= merr_req;
    end
  end
endmodule

// File: rtl/sts_dbc.sv
module sts_dbc (
  input  logic clk,
  input  logic rst_n,
  input  logic np_cmd,
  input  logic dbc_cmd,
  input  logic dbc_acc_n,
  output logic dbca_q,
  output logic req_q
);
  logic grant, dbca_d, req_d;

  always_comb begin
    grant  = np_cmd && dbc_cmd && !dbc_acc_n;
    req_d  = grant;
    dbca_d = np_cmd ? grant : dbca_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbca_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      dbca_q <= dbca_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/sts_flag_cell.sv
module sts_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_live,
  input  logic opt_on,
  input  logic np_take,
  input  logic poll_cmd,
  input  logic hard_clr,
  input  logic next_sel,
  input  logic upd_sel,
  output logic live_q,
  output logic rep_q
);
  logic live_d, rep_d;

  always_comb begin
    rep_d = rep_q;
    if (!opt_on || hard_clr) begin
      rep_d = 1'b0;
    end else if (np_take) begin
      rep_d = next_sel ? live_q : 1'b0;
    end else if (poll_cmd && upd_sel) begin
      rep_d = rep_q | live_q;
    end
    live_d = (clr_live ? 1'b0 : live_q) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      rep_q  <= 1'b0;
    end else begin
      live_q <= live_d;
      rep_q  <= rep_d;
    end
  end
endmodule

// File: rtl/rt_status_ctl.sv
module rt_status_ctl
  import sts_pkg::*;
#(
  parameter int SAMPLE_TICKS = 2,
  parameter int MERR_WIN     = 25,
  parameter int NFLAG        = 2,
  parameter int NBIT         = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_kind,
  input  logic       busy_n,
  input  logic       srq_n,
  input  logic       merr_req,
  input  logic       dbc_acc_n,
  input  logic       ssf_err_n,
  input  logic       hs_fail,
  input  logic       tx_timeout,
  input  logic       lt_fail,
  input  logic       selftest_fail,
  input  logic       addr_par_err,
  input  logic       opt_en_n,
  input  logic       opt_next_n,
  input  logic       opt_upd_n,
  input  logic       opt_bitd_n,
  output logic       sts_merr,
  output logic       sts_busy,
  output logic       sts_srq,
  output logic       sts_dbca,
  output logic       sts_tf,
  output logic       sts_ssf,
  output logic       bit_txto,
  output logic       bit_hsf,
  output logic       bit_ltf,
  output logic       dbc_req
);
  localparam int FL_TF  = 0;
  localparam int FL_SSF = 1;

  logic poll_cmd, np_cmd, opt_on, next_sel, upd_sel, bitd_sel;
  logic hard_clr, keep_bits, clr_live, np_take, fault_any;
  logic fresh_q, fresh_d, inh_q, inh_d;
  logic [NFLAG-1:0] fset, flive, frep;
  logic [NBIT-1:0]  bset, bits_q, bits_d;

  always_comb begin
    poll_cmd  = cmd_valid && kind_is_poll(cmd_kind);
    np_cmd    = cmd_valid && !kind_is_poll(cmd_kind);
    opt_on    = !opt_en_n;
    next_sel  = opt_on && !opt_next_n;
    upd_sel   = opt_on && !opt_upd_n;
    bitd_sel  = opt_on && !opt_bitd_n;
    hard_clr  = cmd_valid && (cmd_kind == CK_RESET);
    keep_bits = bitd_sel && np_cmd && (cmd_kind == CK_BITRD) && fresh_q;
    np_take   = np_cmd && !keep_bits;
    clr_live  = opt_on ? np_take : hard_clr;
    fset[FL_TF]  = lt_fail | tx_timeout | selftest_fail | addr_par_err;
    fset[FL_SSF] = ~ssf_err_n | hs_fail;
    fault_any = |fset;
    bset = {lt_fail, hs_fail, tx_timeout};
    fresh_d = (np_cmd ? 1'b0 : fresh_q) | fault_any;
    inh_d = inh_q;
    if (cmd_valid && cmd_kind == CK_INHTF) inh_d = 1'b1;
    if (cmd_valid && (cmd_kind == CK_OVRTF || cmd_kind == CK_RESET)) inh_d = 1'b0;
    bits_d = (clr_live ? '0 : bits_q) | bset;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NFLAG; gi++) begin : g_flag
      sts_flag_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (fset[gi]),
        .clr_live (clr_live),
        .opt_on   (opt_on),
        .np_take  (np_take),
        .poll_cmd (poll_cmd),
        .hard_clr (hard_clr),
        .next_sel (next_sel),
        .upd_sel  (upd_sel),
        .live_q   (flive[gi]),
        .rep_q    (frep[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= 1'b0;
      inh_q   <= 1'b0;
      bits_q  <= '0;
    end else begin
      fresh_q <= fresh_d;
      inh_q   <= inh_d;
      bits_q  <= bits_d;
    end
  end

  sts_sample #(.SAMPLE_TICKS(SAMPLE_TICKS), .MERR_WIN(MERR_WIN)) u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .np_cmd   (np_cmd),
    .tick_en  (tick_en),
    .busy_n   (busy_n),
    .srq_n    (srq_n),
    .merr_req (merr_req),
    .busy_q   (sts_busy),
    .srq_q    (sts_srq),
    .merr_q   (sts_merr)
  );

  sts_dbc u_dbc (
    .clk       (clk),
    .rst_n     (rst_n),
    .np_cmd    (np_cmd),
    .dbc_cmd   (cmd_kind == CK_DBC),
    .dbc_acc_n (dbc_acc_n),
    .dbca_q    (sts_dbca),
    .req_q     (dbc_req)
  );

  always_comb begin
    sts_tf   = (opt_on ? frep[FL_TF] : flive[FL_TF]) && !inh_q;
    sts_ssf  = opt_on ? (frep[FL_SSF] | ~ssf_err_n) : flive[FL_SSF];
    bit_txto = bits_q[0];
    bit_hsf  = bits_q[1];
    bit_ltf  = bits_q[2];
  end
endmodule

// File: rtl/rt_status_chk.sv
module rt_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_kind,
  input logic       dbc_acc_n,
  input logic       merr_req,
  input logic       opt_en_n,
  input logic       ssf_err_n,
  input logic       hs_fail,
  input logic       tx_timeout,
  input logic       lt_fail,
  input logic       selftest_fail,
  input logic       addr_par_err,
  input logic       sts_tf,
  input logic       sts_ssf,
  input logic       sts_dbca,
  input logic       sts_merr,
  input logic       bit_txto,
  input logic       bit_hsf,
  input logic       bit_ltf,
  input logic       dbc_req
);
  logic quiet;
  assign quiet = ssf_err_n && !hs_fail && !tx_timeout && !lt_fail && !selftest_fail && !addr_par_err;

  AST_DBCREQ_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    dbc_req |-> $past(cmd_valid && cmd_kind == 3'd7 && !dbc_acc_n)); // R6

  AST_RESET_CLEARS_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd4 && quiet) |=> !sts_tf); // R2

  AST_RESET_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd4 && quiet) |=> !bit_txto && !bit_hsf && !bit_ltf); // R10

  AST_INHIBIT_MASKS_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 3'd5) |=> !sts_tf); // R3

  AST_SSF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_en_n && sts_ssf && !(cmd_valid && cmd_kind == 3'd4)) |=> (!opt_en_n || sts_ssf)); // R1

  AST_POLL_KEEPS_DBCA: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_kind == 3'd1 || cmd_kind == 3'd2)) |=> $stable(sts_dbca)); // R12

  AST_MERR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_merr) |-> $past(merr_req)); // R5
endmodule

bind rt_status_ctl rt_status_chk u_chk (.*);

// File: tb/rt_status_ctl_tb.sv
module rt_status_ctl_tb;
  localparam int CLK_NS = 20;
  localparam int TICKDIV = 25;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_kind = 3'd0;
  logic busy_n = 1'b1, srq_n = 1'b1, merr_req = 1'b0, dbc_acc_n = 1'b1;
  logic ssf_err_n = 1'b1, hs_fail = 1'b0, tx_timeout = 1'b0, lt_fail = 1'b0;
  logic selftest_fail = 1'b0, addr_par_err = 1'b0;
  logic opt_en_n = 1'b1, opt_next_n = 1'b1, opt_upd_n = 1'b1, opt_bitd_n = 1'b1;
  logic sts_merr, sts_busy, sts_srq, sts_dbca, sts_tf, sts_ssf;
  logic bit_txto, bit_hsf, bit_ltf, dbc_req;

  int n_chk = 0, n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  rt_status_ctl u_dut (.*);

  // slow tick generator
  int tdiv = 0;
  always @(posedge clk) begin
    #1;
    tdiv = (tdiv == TICKDIV-1) ? 0 : tdiv + 1;
    tick_en = (tdiv == 0);
  end

  // behavioural reference model
  bit m_ltf, m_lssf, m_rtf, m_rssf, m_inh, m_fresh;
  bit m_bto, m_bhs, m_blt;
  bit m_busy, m_srq, m_arm, m_merr, m_won, m_prev, m_dbca, m_dreq;
  int m_tc, m_wc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ltf, m_lssf, m_rtf, m_rssf, m_inh, m_fresh} = '0;
      {m_bto, m_bhs, m_blt} = '0;
      {m_busy, m_srq, m_arm, m_merr, m_won, m_prev, m_dbca, m_dreq} = '0;
      m_tc = 0; m_wc = 0;
    end else begin
      bit pl, np, en, keep, clr, tset, sset, rst_cmd;
      pl = cmd_valid && (cmd_kind == 1 || cmd_kind == 2);
      np = cmd_valid && !pl;
      en = !opt_en_n;
      rst_cmd = cmd_valid && cmd_kind == 4;
      tset = lt_fail || tx_timeout || selftest_fail || addr_par_err;
      sset = !ssf_err_n || hs_fail;
      keep = en && !opt_bitd_n && np && cmd_kind == 3 && m_fresh;
      clr = en ? (np && !keep) : rst_cmd;
      if (!en || rst_cmd) begin m_rtf = 0; m_rssf = 0; end
      else if (np && !keep) begin
        m_rtf = !opt_next_n ? m_ltf : 0;
        m_rssf = !opt_next_n ? m_lssf : 0;
      end else if (pl && !opt_upd_n) begin
        m_rtf = m_rtf | m_ltf; m_rssf = m_rssf | m_lssf;
      end
      if (clr) begin m_ltf = 0; m_lssf = 0; m_bto = 0; m_bhs = 0; m_blt = 0; end
      m_ltf |= tset; m_lssf |= sset;
      m_bto |= tx_timeout; m_bhs |= hs_fail; m_blt |= lt_fail;
      if (np) m_fresh = 0;
      m_fresh |= (tset || sset);
      if (cmd_valid && cmd_kind == 5) m_inh = 1;
      if (cmd_valid && (cmd_kind == 6 || cmd_kind == 4)) m_inh = 0;
      if (np) begin m_busy = 0; m_srq = 0; m_arm = 1; m_tc = 0; end
      else if (m_arm && tick_en) begin
        m_tc++;
        if (m_tc == 2) begin m_busy = !busy_n; m_srq = !srq_n; m_arm = 0; end
      end
      if (np) begin m_merr = 0; m_won = 1; m_wc = 0; end
      else if (m_won) begin
        if (merr_req && !m_prev) m_merr = 1;
        m_wc++;
        if (m_wc == 25) m_won = 0;
      end
      m_prev = merr_req;
      m_dreq = np && cmd_kind == 7 && !dbc_acc_n;
      if (np) m_dbca = m_dreq;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  always @(negedge clk) if (cmp_on) begin
    bit etf, essf;
    etf  = (!opt_en_n ? m_rtf : m_ltf) && !m_inh;
    essf = !opt_en_n ? (m_rssf || !ssf_err_n) : m_lssf;
    chk("R2 tf", sts_tf, etf);
    chk("R1 ssf", sts_ssf, essf);
    chk("R4 busy", sts_busy, m_busy);
    chk("R4 srq", sts_srq, m_srq);
    chk("R5 merr", sts_merr, m_merr);
    chk("R6 dbca", sts_dbca, m_dbca);
    chk("R6 dbc_req", dbc_req, m_dreq);
    chk("R10 txto", bit_txto, m_bto);
    chk("R10 hsf", bit_hsf, m_bhs);
    chk("R10 ltf", bit_ltf, m_blt);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cmd(int k);
    cmd_valid = 1; cmd_kind = 3'(k);
    @(posedge clk); #2;
    cmd_valid = 0; cmd_kind = 0;
    idle(3);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(posedge clk); #2; s = 0;
    idle(3);
  endtask

  task automatic hard_reset(bit en_n, bit nx_n, bit up_n, bit bd_n);
    cmp_on = 0;
    rst_n = 0;
    opt_en_n = en_n; opt_next_n = nx_n; opt_upd_n = up_n; opt_bitd_n = bd_n;
    idle(2);
    rst_n = 1;
    idle(1);
    cmp_on = 1;
  endtask

  task automatic directed(string req, logic act, logic exp);
    #10; chk(req, act, exp); #(CLK_NS - 10);
  endtask

  bit wd_fired = 0;

  initial begin
    fork
      begin
        // reset state
        hard_reset(1, 1, 1, 1);
        directed("R2 reset tf", sts_tf, 0);
        directed("R2 reset dbc_req", dbc_req, 0);
        // R1 default subsystem flag
        ssf_err_n = 0; @(posedge clk); #2; ssf_err_n = 1; idle(2);
        cmd(0); cmd(3);
        directed("R1 ssf sticky", sts_ssf, 1);
        cmd(4);
        directed("R1 ssf cleared by reset cmd", sts_ssf, 0);
        pulse(hs_fail);
        directed("R1 ssf from handshake", sts_ssf, 1);
        cmd(4);
        // R2 each tf cause
        pulse(lt_fail); cmd(0); directed("R2 tf loop", sts_tf, 1); cmd(4);
        pulse(tx_timeout); directed("R2 tf timeout", sts_tf, 1); cmd(4);
        pulse(selftest_fail); directed("R2 tf selftest", sts_tf, 1); cmd(4);
        pulse(addr_par_err); directed("R2 tf parity", sts_tf, 1); cmd(4);
        // R3 inhibit
        pulse(selftest_fail); cmd(5);
        directed("R3 inhibited", sts_tf, 0);
        cmd(6);
        directed("R3 override", sts_tf, 1);
        cmd(5); cmd(4); pulse(tx_timeout);
        directed("R3 reset lifts inhibit", sts_tf, 1);
        cmd(4);
        // R4 busy / srq
        busy_n = 0; cmd(0); idle(70);
        directed("R4 busy sampled", sts_busy, 1);
        busy_n = 1; srq_n = 0; cmd(0); idle(70);
        directed("R4 srq sampled", sts_srq, 1);
        directed("R4 busy cleared", sts_busy, 0);
        // R12 poll keeps status bits
        srq_n = 1; cmd(1); idle(70);
        directed("R12 poll keeps srq", sts_srq, 1);
        // R5 merr window
        cmd(0); idle(2); pulse(merr_req);
        directed("R5 merr inside window", sts_merr, 1);
        cmd(0); idle(30); pulse(merr_req);
        directed("R5 merr outside window", sts_merr, 0);
        // R6 dbc
        dbc_acc_n = 1; cmd(7);
        directed("R6 dbca refused", sts_dbca, 0);
        dbc_acc_n = 0; cmd(7);
        directed("R6 dbca granted", sts_dbca, 1);
        cmd(2); directed("R12 poll keeps dbca", sts_dbca, 1);
        cmd(0); directed("R6 dbca cleared", sts_dbca, 0);
        dbc_acc_n = 1;
        // R11 options ignored while enable inactive
        hard_reset(1, 0, 0, 0);
        pulse(lt_fail); cmd(0); cmd(0);
        directed("R11 tf kept", sts_tf, 1);
        cmd(3); directed("R11 bit kept", bit_ltf, 1);
        // R7 base option mode
        hard_reset(0, 1, 1, 1);
        pulse(lt_fail); cmd(1);
        directed("R7 tf not shown on poll", sts_tf, 0);
        cmd(0); directed("R7 bits cleared", bit_ltf, 0);
        ssf_err_n = 0; cmd(0);
        directed("R7 ssf follows level", sts_ssf, 1);
        ssf_err_n = 1; idle(1); cmd(0);
        directed("R7 ssf gone", sts_ssf, 0);
        // R8 status update
        hard_reset(0, 1, 0, 1);
        pulse(tx_timeout); cmd(1);
        directed("R8 poll shows tf", sts_tf, 1);
        cmd(2); directed("R8 repeat poll", sts_tf, 1);
        cmd(0); directed("R8 cleared", sts_tf, 0);
        pulse(hs_fail); cmd(0); cmd(1);
        directed("R8 late poll not shown", sts_ssf, 0);
        // R9 next status
        hard_reset(0, 0, 1, 1);
        pulse(hs_fail); cmd(1);
        directed("R9 poll not shown", sts_ssf, 0);
        cmd(0); directed("R9 shown next", sts_ssf, 1);
        cmd(2); directed("R9 poll keeps", sts_ssf, 1);
        cmd(0); directed("R9 cleared", sts_ssf, 0);
        // R10 BIT decode preserve
        hard_reset(0, 1, 0, 0);
        pulse(lt_fail); cmd(1); cmd(3);
        directed("R10 bit preserved", bit_ltf, 1);
        cmd(0); directed("R10 bit cleared", bit_ltf, 0);
        pulse(tx_timeout); cmd(0); cmd(3);
        directed("R10 late read clears", bit_txto, 0);
        idle(5);
      end
      begin
        repeat (200000) @(posedge clk);
        wd_fired = 1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule